// File: doc/BRIEF.md
# Round-Robin Transmit Line Scanner

This block picks which of several outgoing serial lines the host may load next. It keeps a per-line enable mask, written through a transmit control write. For each line it also sees a ready input from that line's serialiser. When something changes, it searches the lines in circular order, starting with the line after the one it last reported. It reports the first line that is both enabled and still available. The chosen line number and a transmit-ready flag both appear in a status word, and a transmit interrupt is derived from them.

A low-byte write of the transmit data word, made while scanning is enabled and transmit ready is set, hands a 7-bit character to the reported line. Per line, the interface is valid/ready: `line_load` is the valid strobe and `line_rdy` is the ready input. A line that has taken a character counts as busy until its ready input goes low and then high again. So a character is never offered twice to the same ready pulse, and the block waits for as long as the serialisers hold their ready low.

Top module: `tx_line_scanner`

## Requirements
- R1: After reset, transmit ready is 0, the reported line is 0, the interrupt is 0, no load strobe is active, and the stored data word is 0.
- R2: A scan checks lines reported+1, reported+2, … modulo NUM_LINES, and checks the reported line itself last. It picks the first line whose enable bit is set and which is available. It writes that line to `tx_line` and to `stat_word[10:8]`, and sets `tx_ready` and `stat_word[15]`. All other status bits are 0. The result shows on the second rising edge after the triggering input is presented.
- R3: If no line qualifies, the scan clears transmit ready and leaves the reported line unchanged.
- R4: A scan is started by a control write, by a low-byte data write, by a rising edge on any `line_rdy` bit, or by `scan_en` rising.
- R5: A low-byte data write (`tdr_be[0]`=1) with `scan_en` and transmit ready both set pulses the reported line's bit of `line_load` for one cycle, on the edge that captures the write. On that same edge `line_char` takes `tdr_wdata[6:0]`.
- R6: A write with `tdr_be`=2'b10 stores `tdr_wdata[15:8]` into `tdr_word[15:8]`, keeps the low byte, and produces no load strobe.
- R7: `tx_irq` is high exactly while `tx_int_en` and transmit ready are both high, with no register between them. Raising `tx_int_en` while ready is already set raises the interrupt in the same cycle.
- R8: A line that has received a load strobe is unavailable to the scan until its `line_rdy` input rises again.
- R9: While `scan_en` is low, transmit ready clears on the next edge and data writes produce no load strobe.
- R10: Each control write replaces the whole enable mask, with bit i enabling line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Master scan enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| ctl_wr | input | 1 | Transmit control write strobe |
| ctl_wdata | input | NUM_LINES | New per-line enable mask |
| tdr_wr | input | 1 | Transmit data write strobe |
| tdr_be | input | 2 | Byte enables of the data write (bit 0 low byte) |
| tdr_wdata | input | 16 | Data write word |
| line_rdy | input | NUM_LINES | Per-line ready from the serialisers |
| line_load | output | NUM_LINES | Per-line one-cycle character load strobe |
| line_char | output | 7 | Character presented with the load strobe |
| tdr_word | output | 16 | Last stored data word |
| stat_word | output | 16 | Status: bit 15 ready, bits 10:8 reported line |
| tx_ready | output | 1 | Transmit ready |
| tx_line | output | LINE_W | Reported line |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is the self-wrap, where the only eligible line is the one already reported, so the search must travel all the way round to it. The vector table reaches it by narrowing the enables to a single line just after that line has been reported. The second is the busy state after a load. The bench loads a line that is the only enabled one, sees transmit ready drop, and then pulses that line's ready low and high to bring it back.

// File: rtl/tls_pkg.sv
package tls_pkg;
  localparam int STAT_RDY_BIT  = 15;
  localparam int STAT_LINE_LSB = 8;
  localparam int CHAR_W        = 7;
  localparam int WORD_W        = 16;
endpackage

// File: rtl/tls_ready_track.sv
module tls_ready_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_rdy,
  input  logic [N-1:0] load_mask,
  output logic [N-1:0] avail,
  output logic         any_rise
);
  logic [N-1:0] rdy_q;
  logic [N-1:0] rise;

  assign rise     = line_rdy & ~rdy_q;
  assign any_rise = |rise;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic busy_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q[i] <= 1'b0;
        busy_q   <= 1'b0;
      end else begin
        rdy_q[i] <= line_rdy[i];
        if (load_mask[i])  busy_q <= 1'b1;
        else if (rise[i])  busy_q <= 1'b0;
      end
    end
    assign avail[i] = line_rdy[i] & ~busy_q;

    // R8: a loaded line is busy in the following cycle
    p_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_mask[i] |=> !avail[i]);
  end
endmodule

// File: rtl/tls_rr_pick.sv
module tls_rr_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [W-1:0] last,
  input  logic [N-1:0] elig,
  output logic         found,
  output logic [W-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= N; k++) begin
      automatic int idx = (int'(last) + k) % N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = W'(idx);
      end
    end
  end
endmodule

// File: rtl/tls_load_drive.sv
module tls_load_drive
  import tls_pkg::*;
#(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              scan_en,
  input  logic              ready,
  input  logic [W-1:0]      line,
  output logic              lo_wr,
  output logic [N-1:0]      fire_mask,
  output logic [N-1:0]      line_load,
  output logic [CHAR_W-1:0] line_char,
  output logic [WORD_W-1:0] word_q
);
  logic fire;

  assign lo_wr     = wr && be[0];
  assign fire      = lo_wr && scan_en && ready;
  assign fire_mask = fire ? ({{(N-1){1'b0}}, 1'b1} << line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_load <= '0;
      line_char <= '0;
      word_q    <= '0;
    end else begin
      line_load <= fire_mask;
      if (fire)        line_char   <= wdata[CHAR_W-1:0];
      if (lo_wr)       word_q[7:0] <= wdata[7:0];
      if (wr && be[1]) word_q[15:8] <= wdata[15:8];
    end
  end

  p_load_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_load));

  p_hi_noload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be == 2'b10) |=> (line_load == '0));
endmodule

// File: rtl/tx_line_scanner.sv
module tx_line_scanner
  import tls_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 tx_int_en,
  input  logic                 ctl_wr,
  input  logic [NUM_LINES-1:0] ctl_wdata,
  input  logic                 tdr_wr,
  input  logic [1:0]           tdr_be,
  input  logic [WORD_W-1:0]    tdr_wdata,
  input  logic [NUM_LINES-1:0] line_rdy,
  output logic [NUM_LINES-1:0] line_load,
  output logic [CHAR_W-1:0]    line_char,
  output logic [WORD_W-1:0]    tdr_word,
  output logic [WORD_W-1:0]    stat_word,
  output logic                 tx_ready,
  output logic [LINE_W-1:0]    tx_line,
  output logic                 tx_irq
);
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] avail;
  logic [NUM_LINES-1:0] fire_mask;
  logic                 any_rise;
  logic                 lo_wr;
  logic                 scan_en_q;
  logic                 pend_q;
  logic                 ready_q;
  logic [LINE_W-1:0]    line_q;
  logic                 found;
  logic [LINE_W-1:0]    pick;

  tls_ready_track #(.N(NUM_LINES)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_rdy (line_rdy),
    .load_mask(fire_mask),
    .avail    (avail),
    .any_rise (any_rise)
  );

  tls_rr_pick #(.N(NUM_LINES), .W(LINE_W)) u_pick (
    .last (line_q),
    .elig (en_q & avail),
    .found(found),
    .pick (pick)
  );

  tls_load_drive #(.N(NUM_LINES), .W(LINE_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (tdr_wr),
    .be       (tdr_be),
    .wdata    (tdr_wdata),
    .scan_en  (scan_en),
    .ready    (ready_q),
    .line     (line_q),
    .lo_wr    (lo_wr),
    .fire_mask(fire_mask),
    .line_load(line_load),
    .line_char(line_char),
    .word_q   (tdr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      scan_en_q <= 1'b0;
      pend_q    <= 1'b0;
      ready_q   <= 1'b0;
      line_q    <= '0;
    end else begin
      if (ctl_wr) en_q <= ctl_wdata;
      scan_en_q <= scan_en;
      pend_q    <= ctl_wr | lo_wr | any_rise | (scan_en & ~scan_en_q);
      if (!scan_en) begin
        ready_q <= 1'b0;
      end else if (pend_q) begin
        ready_q <= found;
        if (found) line_q <= pick;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_RDY_BIT] = ready_q;
    stat_word[STAT_LINE_LSB +: LINE_W] = line_q;
  end

  assign tx_ready = ready_q;
  assign tx_line  = line_q;
  assign tx_irq   = tx_int_en & ready_q;

  p_keep_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> $stable(line_q));

  p_noscan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !ready_q);

  p_load_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_load) |-> $past(ready_q && scan_en));
endmodule

// File: tb/tx_line_scanner_test.sv
`timescale 1ns/1ps
module tx_line_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        tx_int_en = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        tdr_wr = 1'b0;
  logic [1:0]  tdr_be = '0;
  logic [15:0] tdr_wdata = '0;
  logic [7:0]  line_rdy = '0;
  logic [7:0]  line_load;
  logic [6:0]  line_char;
  logic [15:0] tdr_word;
  logic [15:0] stat_word;
  logic        tx_ready;
  logic [2:0]  tx_line;
  logic        tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_line_scanner uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tx_int_en(tx_int_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tdr_wr(tdr_wr),
    .tdr_be(tdr_be), .tdr_wdata(tdr_wdata), .line_rdy(line_rdy),
    .line_load(line_load), .line_char(line_char), .tdr_word(tdr_word),
    .stat_word(stat_word), .tx_ready(tx_ready), .tx_line(tx_line),
    .tx_irq(tx_irq)
  );

  // {enable mask, line ready, expected line, expected ready}
  localparam logic [19:0] VEC [10] = '{
    {8'hFF, 8'hFF, 3'd1, 1'b1},
    {8'hFF, 8'hFF, 3'd2, 1'b1},
    {8'h01, 8'hFF, 3'd0, 1'b1},
    {8'h00, 8'hFF, 3'd0, 1'b0},
    {8'h80, 8'h80, 3'd7, 1'b1},
    {8'hFF, 8'h00, 3'd7, 1'b0},
    {8'hFF, 8'h08, 3'd3, 1'b1},
    {8'h0C, 8'h0C, 3'd2, 1'b1},
    {8'h04, 8'h04, 3'd2, 1'b1},
    {8'h10, 8'hFF, 3'd4, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_data(input logic [1:0] be, input logic [15:0] d);
    tdr_wr = 1'b1; tdr_be = be; tdr_wdata = d;
    tick(1);
    tdr_wr = 1'b0; tdr_be = '0;
  endtask

  initial begin
    tick(3);
    // R1: reset state
    chk("R1", "ready", int'(tx_ready), 0);
    chk("R1", "line", int'(tx_line), 0);
    chk("R1", "irq", int'(tx_irq), 0);
    chk("R1", "load", int'(line_load), 0);
    chk("R1", "word", int'(tdr_word), 0);
    rst_n = 1'b1;
    tick(1);
    scan_en = 1'b1;
    tick(3);

    // R2 R3 R4 R10: rotating search vectors, control write as the trigger
    for (int v = 0; v < 10; v++) begin
      line_rdy  = VEC[v][11:4];
      ctl_wdata = VEC[v][19:12];
      ctl_wr    = 1'b1;
      tick(1);
      ctl_wr = 1'b0;
      tick(1);
      chk("R2", $sformatf("vec%0d line", v), int'(tx_line), int'(VEC[v][3:1]));
      chk("R3", $sformatf("vec%0d ready", v), int'(tx_ready), int'(VEC[v][0]));
      chk("R2", $sformatf("vec%0d stat", v), int'(stat_word),
          int'({VEC[v][0], 4'b0, VEC[v][3:1], 8'b0}));
    end

    // R7: interrupt follows enable immediately
    chk("R7", "irq disabled", int'(tx_irq), 0);
    tx_int_en = 1'b1;
    #1;
    chk("R7", "irq immediate", int'(tx_irq), 1);
    tick(1);

    // R5: low-byte write loads line 4
    write_data(2'b01, 16'h00C5);
    chk("R5", "load mask", int'(line_load), 'h10);
    chk("R5", "char", int'(line_char), 'h45);
    tick(1);
    chk("R5", "strobe one cycle", int'(line_load), 0);
    // R8: only enabled line is busy now
    chk("R8", "ready after load", int'(tx_ready), 0);
    chk("R8", "line kept", int'(tx_line), 4);
    chk("R7", "irq drops", int'(tx_irq), 0);
    line_rdy = 8'hEF;
    tick(1);
    line_rdy = 8'hFF;
    tick(2);
    chk("R8", "reassert ready", int'(tx_ready), 1);
    chk("R8", "reassert line", int'(tx_line), 4);

    // R6: high-byte-only write stores, no load
    write_data(2'b10, 16'hAB00);
    chk("R6", "no load", int'(line_load), 0);
    chk("R6", "word", int'(tdr_word), 'hABC5);
    chk("R6", "ready kept", int'(tx_ready), 1);

    // R9: scan disabled
    scan_en = 1'b0;
    tick(1);
    chk("R9", "ready cleared", int'(tx_ready), 0);
    chk("R9", "irq off", int'(tx_irq), 0);
    write_data(2'b01, 16'h0033);
    chk("R9", "no load", int'(line_load), 0);
    chk("R9", "low byte stored", int'(tdr_word), 'hAB33);

    // R4: scan enable rising rescans from line 4 -> line 4 (only enabled)
    scan_en = 1'b1;
    tick(2);
    chk("R4", "rescan ready", int'(tx_ready), 1);
    chk("R4", "rescan line", int'(tx_line), 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule